// File: doc/BRIEF.md
# Master Clock Selector and Divider

This block derives the master clock of a chip from one of four clock sources: the slow clock, the main clock and two PLL outputs. All logic runs on one fast reference clock. Each source arrives as a one-cycle enable pulse (`src_tick`) in that domain, one pulse per source period. The block divides the chosen source with a prescaler to form the processor clock (`pck_en`, plus a square-wave level `pck_lvl`). A second divider then slows that down to form the master clock (`mck_en`), so the processor can run at a higher rate than the master clock.

Software writes one configuration word. It holds a 2-bit source select, a 3-bit prescaler code and a 2-bit master divider code. A switch state machine applies each write without producing a runt period:
- **RUN**: the state after reset; `ready` is high.
- **RUN → DRAIN**: taken on a write. In **DRAIN** the block waits for the terminal count of the current master divider.
- **DRAIN → ALIGN**: the new settings are loaded at that terminal count. In **ALIGN** the block holds its counters until the next pulse of the new source, which only marks the phase.
- **ALIGN → SETTLE**: taken on that pulse. In **SETTLE** the block counts the pulses of the new master clock.
- **SETTLE → RUN**: taken on the second new master pulse; `ready` rises again.
- **any state → DRAIN**: taken on any write during a switch. The latest value written is then the one applied.

The interrupt output is level-sensitive and does not latch.

Top module: `mck_clk_ctrl`

## Requirements
- R1: After reset `ready` is 1 and the configuration is slow source, /1 prescaler and /1 master divider. `mck_en` and `pck_en` therefore pulse once per slow-source period.
- R2: Source select is `wr_data[1:0]`: 0 slow, 1 main, 2 PLL A, 3 UPLL. `pck_en` only pulses in the cycle after a pulse of the selected source.
- R3: Prescaler code is `wr_data[4:2]`: code k in 0..6 divides by 2^k, and code 7 divides by 6. `pck_en` repeats every N pulses of the selected source.
- R4: `pck_lvl` is a square wave with the period of the prescaler. For /6 it is high for 3 source periods and low for 3. For the other codes of 2 or more it is high for half the period, and for /1 it stays high.
- R5: Master divider code is `wr_data[6:5]`: codes 0, 1, 2 and 3 give /1, /2, /3 and /4. `mck_en` pulses only together with `pck_en`, on every M-th one.
- R6: Every write clears `ready` from the next cycle, including a write that repeats the current value.
- R7: A new configuration takes effect only at a master terminal count. From the write to the rise of `ready`, exactly three master pulses appear: the last one of the old setting and two of the new. No gap between master pulses is shorter than the smaller of the old and new periods. `ready` then stays high until the next write.
- R8: `irq` equals `ready` AND `irq_en`. It drops in the cycle after a write.
- R9: A write made while a switch is in progress restarts the switch. The configuration that ends up applied is the last one written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | One pulse per period of each source (bit index = source code) |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 7 | Configuration word {mdiv, pres, sel} |
| irq_en | input | 1 | Enables the ready interrupt |
| pck_en | output | 1 | Processor clock enable pulse |
| pck_lvl | output | 1 | Processor clock square-wave level |
| mck_en | output | 1 | Master clock enable pulse |
| ready | output | 1 | Master clock established |
| irq | output | 1 | Level interrupt request |

## Verification
The bench walks transitions that change only the source, only the prescaler, or both at once. For each one it checks the gaps between master pulses during the switch. A design that loaded new settings mid-period, or that started the new divider off the phase of the new source, would show a gap shorter than either period. The bench counts master pulses between the write and `ready`, which catches a flag that rises one period early or late. It also checks that a repeated identical write and two back-to-back writes each drop `ready`. It checks the 3/3 duty of the divide-by-6 level, which a plain counter compare at the wrong threshold would turn into 2/4 or 4/2.

// File: rtl/mck_pkg.sv
package mck_pkg;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = 2;
    localparam int PRES_W  = 3;
    localparam int MDIV_W  = 2;
    localparam int CFG_W   = SEL_W + PRES_W + MDIV_W;
    localparam int CNT_W   = 6;   // holds limit of the largest prescaler (/64)

    typedef struct packed {
        logic [MDIV_W-1:0] mdiv;
        logic [PRES_W-1:0] pres;
        logic [SEL_W-1:0]  sel;
    } mck_cfg_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_ALIGN  = 2'd2,
        ST_SETTLE = 2'd3
    } sw_state_t;

    // terminal count of the prescaler (divide ratio minus one)
    function automatic logic [CNT_W-1:0] pres_limit(input logic [PRES_W-1:0] code);
        logic [CNT_W:0] ratio;
        if (code == PRES_W'(7)) ratio = (CNT_W+1)'(6);
        else                    ratio = (CNT_W+1)'(1) << code;
        return CNT_W'(ratio - (CNT_W+1)'(1));
    endfunction

    // count below which the level output is high
    function automatic logic [CNT_W-1:0] pres_half(input logic [PRES_W-1:0] code);
        logic [CNT_W:0] ratio;
        if (code == PRES_W'(7)) ratio = (CNT_W+1)'(6);
        else                    ratio = (CNT_W+1)'(1) << code;
        return CNT_W'(ratio >> 1);
    endfunction
endpackage

// File: rtl/mck_src_mux.sv
module mck_src_mux #(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic [NSRC-1:0] src_tick,
    input  logic [SW-1:0]   sel,
    output logic            tick
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (sel == SW'(g));
    end

    assign tick = |hit;
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] lim,
    input  logic [CW-1:0] half,
    output logic          tc,
    output logic          pck_en,
    output logic          pck_lvl
);
    logic [CW-1:0] cnt;

    assign tc = tick && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            pck_en <= 1'b0;
        end else begin
            pck_en <= tc;
            if (load)      cnt <= '0;
            else if (tick) cnt <= tc ? '0 : cnt + CW'(1);
        end
    end

    assign pck_lvl = (lim == '0) || (cnt < half);
endmodule

// File: rtl/mck_master_div.sv
module mck_master_div #(
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_tc,
    input  logic          load,
    input  logic [MW-1:0] lim,
    output logic          m_tc,
    output logic          mck_en
);
    logic [MW-1:0] cnt;

    assign m_tc = p_tc && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            mck_en <= 1'b0;
        end else begin
            mck_en <= m_tc;
            if (load)      cnt <= '0;
            else if (p_tc) cnt <= m_tc ? '0 : cnt + MW'(1);
        end
    end
endmodule

// File: rtl/mck_switch_fsm.sv
module mck_switch_fsm
    import mck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic m_tc,
    input  logic new_tick,
    output logic load,
    output logic count_en,
    output logic ready
);
    sw_state_t st, nxt;
    logic      seen_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_RUN;
            seen_one <= 1'b0;
        end else begin
            st <= nxt;
            if (st != ST_SETTLE) seen_one <= 1'b0;
            else if (m_tc)       seen_one <= 1'b1;
        end
    end

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        count_en = 1'b1;
        ready    = 1'b0;
        unique case (st)
            ST_RUN: begin
                ready = 1'b1;
                if (wr_en) nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wr_en) nxt = ST_DRAIN;
                else if (m_tc) begin
                    load = 1'b1;
                    nxt  = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                count_en = 1'b0;
                if (wr_en)         nxt = ST_DRAIN;
                else if (new_tick) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (wr_en)                 nxt = ST_DRAIN;
                else if (m_tc && seen_one) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/mck_clk_ctrl.sv
module mck_clk_ctrl
    import mck_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int CW    = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_data,
    input  logic             irq_en,
    output logic             pck_en,
    output logic             pck_lvl,
    output logic             mck_en,
    output logic             ready,
    output logic             irq
);
    mck_cfg_t         act_cfg, pend_cfg;
    logic             sel_tick, gated_tick;
    logic             p_tc, m_tc;
    logic             load, count_en;
    logic [CNT_W-1:0] p_lim, p_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg  <= '0;
            pend_cfg <= '0;
        end else begin
            if (wr_en) pend_cfg <= mck_cfg_t'(wr_data);
            if (load)  act_cfg  <= pend_cfg;
        end
    end

    assign p_lim  = pres_limit(act_cfg.pres);
    assign p_half = pres_half(act_cfg.pres);

    mck_src_mux #(.NSRC(N_SRC), .SW(SEL_W)) u_mux (
        .src_tick (src_tick),
        .sel      (act_cfg.sel),
        .tick     (sel_tick)
    );

    assign gated_tick = sel_tick && count_en;

    mck_prescaler #(.CW(CNT_W)) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (gated_tick),
        .load    (load),
        .lim     (p_lim),
        .half    (p_half),
        .tc      (p_tc),
        .pck_en  (pck_en),
        .pck_lvl (pck_lvl)
    );

    mck_master_div #(.MW(MDIV_W)) u_mdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .p_tc   (p_tc),
        .load   (load),
        .lim    (act_cfg.mdiv),
        .m_tc   (m_tc),
        .mck_en (mck_en)
    );

    mck_switch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .m_tc     (m_tc),
        .new_tick (sel_tick),
        .load     (load),
        .count_en (count_en),
        .ready    (ready)
    );

    assign irq = ready && irq_en;
endmodule

// File: rtl/mck_clk_ctrl_chk.sv
module mck_clk_ctrl_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_tick,
    input logic             wr_en,
    input logic             pck_en,
    input logic             mck_en,
    input logic             ready,
    input logic             irq
);
    AST_PCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) pck_en |-> $past(|src_tick)); // R2
    AST_MCK_WITHIN_PCK: assert property (@(posedge clk) disable iff (!rst_n) mck_en |-> pck_en); // R5
    AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !ready); // R6
    AST_READY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> mck_en); // R7
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ready && !wr_en) |=> ready); // R7
    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !irq); // R8
endmodule

bind mck_clk_ctrl mck_clk_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .wr_en    (wr_en),
    .pck_en   (pck_en),
    .mck_en   (mck_en),
    .ready    (ready),
    .irq      (irq)
);

// File: tb/mck_clk_ctrl_tb_top.sv
module mck_clk_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       irq_en = 1'b0;
    logic       pck_en, pck_lvl, mck_en, ready, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    mck_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .pck_en(pck_en),
        .pck_lvl(pck_lvl), .mck_en(mck_en), .ready(ready), .irq(irq)
    );

    // source periods in reference cycles: slow 8, main 1, PLL A 2, UPLL 3
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            src_tick[0] = (cyc % 8) == 0;
            src_tick[1] = 1'b1;
            src_tick[2] = (cyc % 2) == 0;
            src_tick[3] = (cyc % 3) == 0;
        end
    end

    // {sel, pres, mdiv, pck period, mck period}
    localparam logic [38:0] VEC [10] = '{
        {2'd1, 3'd0, 2'd0, 16'd1,   16'd1},
        {2'd2, 3'd1, 2'd1, 16'd4,   16'd8},
        {2'd3, 3'd7, 2'd0, 16'd18,  16'd18},
        {2'd1, 3'd7, 2'd2, 16'd6,   16'd18},
        {2'd0, 3'd2, 2'd3, 16'd32,  16'd128},
        {2'd1, 3'd6, 2'd0, 16'd64,  16'd64},
        {2'd3, 3'd3, 2'd1, 16'd24,  16'd48},
        {2'd2, 3'd0, 2'd3, 16'd2,   16'd8},
        {2'd1, 3'd5, 2'd3, 16'd32,  16'd128},
        {2'd0, 3'd5, 2'd3, 16'd256, 16'd1024}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [2:0] pres, input logic [1:0] mdiv);
        wr_en   = 1'b1;
        wr_data = {mdiv, pres, sel};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_ready(output int n_pulse, output int min_gap);
        int gap = -1;
        int n = 0;
        n_pulse = 0;
        min_gap = 1 << 30;
        while (!ready && n < 8000) begin
            @(negedge clk);
            n++;
            if (gap >= 0) gap++;
            if (mck_en) begin
                n_pulse++;
                if (gap >= 0 && gap < min_gap) min_gap = gap;
                gap = 0;
            end
        end
    endtask

    task automatic period(input bit use_mck, output int p);
        int n = 0;
        while (!(use_mck ? mck_en : pck_en) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!(use_mck ? mck_en : pck_en) && p < 5000);
    endtask

    task automatic count_high(output int h);
        h = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pck_lvl) h++;
        end
    endtask

    initial begin
        int p, np, mg, h, old_mck;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        period(1'b1, p);
        check(p == 8, "R1 reset master period", p, 8);
        period(1'b0, p);
        check(p == 8, "R1 reset prescaler period", p, 8);

        // table walk: R2 R3 R5 R6 R7
        old_mck = 8;
        for (int i = 0; i < 10; i++) begin
            logic [38:0] v = VEC[i];
            int exp_p = int'(v[31:16]);
            int exp_m = int'(v[15:0]);
            int lo = (exp_m < old_mck) ? exp_m : old_mck;
            do_write(v[38:37], v[36:34], v[33:32]);
            check(ready == 1'b0, "R6 ready cleared by write", ready, 0);
            wait_ready(np, mg);
            check(np == 3, "R7 master pulses before ready", np, 3);
            check(mg >= lo, "R7 no short master gap", mg, lo);
            period(1'b0, p);
            check(p == exp_p, "R3 prescaled period", p, exp_p);
            period(1'b1, p);
            check(p == exp_m, "R5 master period", p, exp_m);
            old_mck = exp_m;
        end

        // R6: rewriting the same value still drops ready
        do_write(2'd0, 3'd5, 2'd3);
        check(ready == 1'b0, "R6 same-value write", ready, 0);
        wait_ready(np, mg);
        check(ready == 1'b1, "R6 ready returns", ready, 1);

        // R2 / R4: main source, divide by 6, 3 high 3 low
        do_write(2'd1, 3'd7, 2'd0);
        wait_ready(np, mg);
        count_high(h);
        check(h == 6, "R4 divide-by-6 duty", h, 6);
        do_write(2'd1, 3'd1, 2'd0);
        wait_ready(np, mg);
        count_high(h);
        check(h == 6, "R4 divide-by-2 duty", h, 6);
        do_write(2'd1, 3'd0, 2'd0);
        wait_ready(np, mg);
        count_high(h);
        check(h == 12, "R4 divide-by-1 level high", h, 12);

        // R8: interrupt follows ready and enable
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R8 irq when ready", irq, 1);
        do_write(2'd3, 3'd0, 2'd0);
        check(irq == 1'b0, "R8 irq drops on write", irq, 0);
        wait_ready(np, mg);
        check(irq == 1'b1, "R8 irq on new ready", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R8 irq masked again", irq, 0);

        // R9: back-to-back writes, the last one wins
        do_write(2'd0, 3'd6, 2'd3);
        do_write(2'd2, 3'd1, 2'd0);
        check(ready == 1'b0, "R9 ready low during restart", ready, 0);
        wait_ready(np, mg);
        period(1'b1, p);
        check(p == 4, "R9 last write applied", p, 4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule